// File: doc/BRIEF.md
# Byte-Accessed 16-bit Up/Down Timer Counter

This block is a 16-bit counter that a processor sees through an 8-bit data bus. The counter's low byte and high byte sit at two byte addresses, and a third address holds the overflow flag. The high-byte address does not reach the counter directly. It reaches a shared holding register instead, which makes a 16-bit read or write over two 8-bit accesses behave as one indivisible step. Software reads the low byte first and then the high byte. It writes the high byte first and then the low byte.

The counter advances once per timer tick when the clock-select field is non-zero. A one-bit sequence mode picks how it advances. In the free-running sequence it counts up and wraps. In the dual-slope sequence it climbs to a fixed top value, turns, and descends to zero. Two level outputs flag the top and bottom values. A sticky overflow flag is intended as an interrupt request.

Top module: `tmr16_core`

## Requirements
- R1: Register select `bus_addr` uses 0 for the low byte, 1 for the high-byte holding register, 2 for the flag register (bit 0 = overflow flag, other bits read 0) and 3 for nothing (reads 0, writes ignored). `bus_rdata` is combinational. At address 0 it returns the counter's low byte, and at address 2 it returns the flag register.
- R2: A read strobe at address 0 copies the counter's high byte into the holding register at that clock edge. A read at address 1 returns the holding register.
- R3: A write at address 1 changes only the holding register. The counter value is not altered by it.
- R4: A write at address 0 loads the counter with the holding register as its high byte and `bus_wdata` as its low byte, in one edge. This load takes precedence over a count step in the same cycle, so no step happens in that cycle.
- R5: A count step occurs on a clock edge where `tick` is 1 and `clk_sel` is non-zero. With `clk_sel` = 0 the counter holds its value, while bus reads and writes still work.
- R6: In sequence mode 0 (free run), each step adds one, 0xFFFF wraps to 0x0000, and the wrap step sets the overflow flag.
- R7: In sequence mode 1 (dual slope, top = 0x00FF), a step counts down when the value is at or above 0x00FF and counts up when the value is 0. Otherwise it keeps the previous step's direction. After reset the direction is up.
- R8: In sequence mode 1, a step that lands on 0x0000 sets the overflow flag.
- R9: `at_bottom` is 1 exactly when the counter is 0. `at_top` is 1 exactly when the counter equals 0xFFFF in mode 0, or 0x00FF in mode 1.
- R10: Writing a 1 in bit 0 at address 2 clears the overflow flag, and writing a 0 there leaves it unchanged. If a flag-setting step coincides with the clear, the flag ends up set.
- R11: After reset the counter, the holding register and the overflow flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect at address 0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| tick | input | 1 | Timer clock enable from outside prescaling |
| clk_sel | input | 3 | Clock select; zero stops counting |
| seq_mode | input | 1 | 0 free run, 1 dual slope |
| at_top | output | 1 | Counter at the mode's top value |
| at_bottom | output | 1 | Counter at zero |
| ovf_flag | output | 1 | Sticky overflow flag / interrupt request |

## Verification
The assertions assume that a read strobe and a write strobe never arrive in the same cycle. Under that assumption the holding register has a single cause for each update. One assertion states this assumption directly. The random stimulus picks at most one bus operation per cycle, so it never breaks the assumption. The stimulus covers all select values and flips the sequence mode only rarely, which gives the dual-slope sequence time to reach its top and its bottom.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_FLAG = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic {
    SEQ_FREE = 1'b0,
    SEQ_DUAL = 1'b1
  } seq_mode_e;
endpackage

// File: rtl/tmr16_bytebus.sv
module tmr16_bytebus
  import tmr16_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [BUS_W-1:0]   bus_wdata,
  input  logic [2*BUS_W-1:0] cnt,
  input  logic               flag,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               cpu_load,
  output logic [2*BUS_W-1:0] load_val,
  output logic               flag_clr
);
  localparam int CNT_W = 2 * BUS_W;

  logic [BUS_W-1:0] tmp_q;
  logic             hi_wr;
  logic             lo_rd;

  assign hi_wr    = bus_wr && (bus_addr == REG_HI);
  assign lo_rd    = bus_rd && !bus_wr && (bus_addr == REG_LO);
  assign cpu_load = bus_wr && (bus_addr == REG_LO);
  assign load_val = {tmp_q, bus_wdata};
  assign flag_clr = bus_wr && (bus_addr == REG_FLAG) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmp_q <= '0;
    end else if (hi_wr) begin
      tmp_q <= bus_wdata;
    end else if (lo_rd) begin
      tmp_q <= cnt[CNT_W-1:BUS_W];
    end
  end

  always_comb begin
    case (reg_sel_e'(bus_addr))
      REG_LO:   bus_rdata = cnt[BUS_W-1:0];
      REG_HI:   bus_rdata = tmp_q;
      REG_FLAG: bus_rdata = {{(BUS_W-1){1'b0}}, flag};
      default:  bus_rdata = '0;
    endcase
  end

  // R2: low-byte read captures the counter high byte
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> tmp_q == $past(cnt[CNT_W-1:BUS_W]));

  // R3: high-byte write lands in the holding register
  p_hold_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> tmp_q == $past(bus_wdata));

  // R3: holding register keeps value with no access
  p_hold_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !bus_rd) |=> $stable(tmp_q));
endmodule

// File: rtl/tmr16_count.sv
module tmr16_count #(
  parameter int                 CNT_W    = 16,
  parameter logic [CNT_W-1:0]   DUAL_TOP = 16'h00FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step_en,
  input  logic             dual,
  output logic [CNT_W-1:0] cnt,
  output logic             at_top,
  output logic             at_bottom,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic             up_q;
  logic             up_nx;
  logic             cnt_go;

  function automatic logic heading_up(input logic [CNT_W-1:0] v,
                                      input logic prev_up,
                                      input logic dsl);
    logic r;
    if (!dsl)             r = 1'b1;
    else if (v >= DUAL_TOP) r = 1'b0;
    else if (v == '0)     r = 1'b1;
    else                  r = prev_up;
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] v,
                                               input logic up);
    return up ? (v + ONE) : (v - ONE);
  endfunction

  assign cnt_go    = step_en && !cpu_load;
  assign up_nx     = heading_up(cnt_q, up_q, dual);
  assign cnt_nx    = advance(cnt_q, up_nx);
  assign wrap_evt  = cnt_go && (dual ? (cnt_nx == '0) : (cnt_q == ALL_ONES));
  assign at_bottom = (cnt_q == '0);
  assign at_top    = dual ? (cnt_q == DUAL_TOP) : (cnt_q == ALL_ONES);
  assign cnt       = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (cpu_load) begin
      cnt_q <= load_val;
    end else if (cnt_go) begin
      cnt_q <= cnt_nx;
      up_q  <= up_nx;
    end
  end

  // R4: bus load wins and takes the assembled word
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_load |=> cnt_q == $past(load_val));

  // R5: no load and no step keeps the value
  p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_load && !step_en) |=> $stable(cnt_q));

  // R7: every step moves by exactly one
  p_unit_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_go |=> (cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE));

  // R7: dual slope never steps up from the top
  p_turn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_go && dual && at_top) |=> cnt_q == DUAL_TOP - ONE);
endmodule

// File: rtl/tmr16_ovf.sv
module tmr16_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_evt) flag_q <= 1'b0;
  end

  assign flag = flag_q;

  // R8: a flag-setting step is always recorded
  p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);

  // R10: write-one clear without a coincident set
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !flag_q);

  // R10: flag is sticky otherwise
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt && !set_evt) |=> $stable(flag_q));
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int          BUS_W    = 8,
  parameter int          CS_W     = 3,
  parameter int unsigned DUAL_TOP = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             tick,
  input  logic [CS_W-1:0]  clk_sel,
  input  logic             seq_mode,
  output logic             at_top,
  output logic             at_bottom,
  output logic             ovf_flag
);
  localparam int               CNT_W   = 2 * BUS_W;
  localparam logic [CNT_W-1:0] TOP_VAL = CNT_W'(DUAL_TOP);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;
  logic             cpu_load;
  logic             flag_clr;
  logic             step_en;
  logic             wrap_evt;
  logic             dual;

  assign step_en = tick && (clk_sel != '0);
  assign dual    = (seq_mode == SEQ_DUAL);

  tmr16_bytebus #(.BUS_W(BUS_W)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .cnt       (cnt),
    .flag      (ovf_flag),
    .bus_rdata (bus_rdata),
    .cpu_load  (cpu_load),
    .load_val  (load_val),
    .flag_clr  (flag_clr)
  );

  tmr16_count #(.CNT_W(CNT_W), .DUAL_TOP(TOP_VAL)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_load  (cpu_load),
    .load_val  (load_val),
    .step_en   (step_en),
    .dual      (dual),
    .cnt       (cnt),
    .at_top    (at_top),
    .at_bottom (at_bottom),
    .wrap_evt  (wrap_evt)
  );

  tmr16_ovf u_ovf (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (wrap_evt),
    .clr_evt (flag_clr),
    .flag    (ovf_flag)
  );

  // R2: input assumption, one bus operation per cycle
  p_one_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  // R9: top and bottom never coincide
  p_top_bottom_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(at_top && at_bottom));

  // R6: free-run step from the top lands at the bottom and flags it
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual && at_top && step_en && !cpu_load && !(seq_mode != $past(seq_mode)))
      |=> at_bottom && ovf_flag);

  // R3: high-byte write alone does not move a stopped counter
  p_hi_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_HI && !step_en) |=> $stable(cnt));
endmodule

// File: tb/test_tmr16_core.sv
module test_tmr16_core;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tick = 1'b0;
  logic [2:0] clk_sel = '0;
  logic       seq_mode = 1'b0;
  logic       at_top;
  logic       at_bottom;
  logic       ovf_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_cnt = '0;
  logic [7:0]  m_tmp = '0;
  logic        m_flg = 1'b0;
  logic        m_dir = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr16_core i_tmr16_core (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick(tick), .clk_sel(clk_sel), .seq_mode(seq_mode),
    .at_top(at_top), .at_bottom(at_bottom), .ovf_flag(ovf_flag)
  );

  // {overflow, direction_up, next value}
  function automatic logic [17:0] model_next(input logic [15:0] c, input logic d,
                                             input logic md);
    logic [15:0] n;
    logic nd;
    logic o;
    if (!md) begin
      n = c + 16'd1; nd = 1'b1; o = (c == 16'hFFFF);
    end else begin
      if (c >= 16'h00FF)     nd = 1'b0;
      else if (c == 16'h0)   nd = 1'b1;
      else                   nd = d;
      n = nd ? c + 16'd1 : c - 16'd1;
      o = (n == 16'h0000);
    end
    return {o, nd, n};
  endfunction

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  // compare combinational outputs against the model for the current inputs
  task automatic compare_now();
    logic [7:0] er;
    case (bus_addr)
      2'd0: er = m_cnt[7:0];
      2'd1: er = m_tmp;
      2'd2: er = {7'b0, m_flg};
      default: er = 8'h00;
    endcase
    chk({8'h0, bus_rdata}, {8'h0, er}, (bus_addr == 2'd1) ? "R2 rdata" : "R1 rdata");
    chk({15'h0, at_top}, {15'h0, seq_mode ? (m_cnt == 16'h00FF) : (m_cnt == 16'hFFFF)}, "R9 at_top");
    chk({15'h0, at_bottom}, {15'h0, m_cnt == 16'h0}, "R9 at_bottom");
    chk({15'h0, ovf_flag}, {15'h0, m_flg}, "R10 ovf_flag");
  endtask

  // one clock cycle: drive at falling edge, check, update model at rising edge
  task automatic cyc(input logic [1:0] a, input logic w, input logic r, input logic [7:0] d,
                     input logic tk, input logic [2:0] cs, input logic md);
    logic        step;
    logic        setv;
    logic [17:0] nx;
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    tick = tk; clk_sel = cs; seq_mode = md;
    #1;
    compare_now();
    step = tk && (cs != 3'd0) && !(w && a == 2'd0);
    nx   = model_next(m_cnt, m_dir, md);
    setv = step && nx[17];
    @(posedge clk);
    if (w && a == 2'd1)      m_tmp = d;
    else if (r && a == 2'd0) m_tmp = m_cnt[15:8];
    m_flg = setv | (m_flg & ~(w && a == 2'd2 && d[0]));
    if (w && a == 2'd0) m_cnt = {m_tmp_prev(w, a, d), d};
    else if (step) begin m_cnt = nx[15:0]; m_dir = nx[16]; end
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; tick = 1'b0;
  endtask

  // holding register value used by a low write (unchanged by that write)
  function automatic logic [7:0] m_tmp_prev(input logic w, input logic [1:0] a, input logic [7:0] d);
    return m_tmp;
  endfunction

  task automatic look(input logic [1:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a; bus_wr = 1'b0; bus_rd = 1'b0; tick = 1'b0;
    #1;
    chk({8'h0, bus_rdata}, {8'h0, exp}, tag);
  endtask

  task automatic load16(input logic [15:0] v, input logic md);
    cyc(2'd1, 1'b1, 1'b0, v[15:8], 1'b0, 3'd1, md);
    cyc(2'd0, 1'b1, 1'b0, v[7:0], 1'b0, 3'd1, md);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    look(2'd0, 8'h00, "R11 low byte after reset");
    look(2'd1, 8'h00, "R11 holding after reset");
    look(2'd2, 8'h00, "R11 flag after reset");
    chk({15'h0, at_bottom}, 16'h1, "R11 at_bottom after reset");

    // R3: high write leaves a stopped counter alone
    cyc(2'd1, 1'b1, 1'b0, 8'hAB, 1'b1, 3'd0, 1'b0);
    look(2'd1, 8'hAB, "R3 holding takes high write");
    chk({15'h0, at_bottom}, 16'h1, "R3 counter still zero");
    cyc(2'd0, 1'b0, 1'b1, 8'h00, 1'b0, 3'd0, 1'b0);
    look(2'd1, 8'h00, "R2 low read captured high byte 0");

    // R4: atomic load beats a same-cycle step
    cyc(2'd1, 1'b1, 1'b0, 8'h12, 1'b0, 3'd1, 1'b0);
    cyc(2'd0, 1'b1, 1'b0, 8'h34, 1'b1, 3'd1, 1'b0);
    look(2'd0, 8'h34, "R4 low byte loaded, no step");
    cyc(2'd1, 1'b1, 1'b0, 8'h00, 1'b0, 3'd1, 1'b0);
    cyc(2'd0, 1'b0, 1'b1, 8'h00, 1'b0, 3'd1, 1'b0);
    look(2'd1, 8'h12, "R4 high byte loaded from holding");

    // R5: clock select zero stops counting
    for (int i = 0; i < 4; i++) cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd0, 1'b0);
    look(2'd0, 8'h34, "R5 stopped with clk_sel zero");
    cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd5, 1'b0);
    look(2'd0, 8'h35, "R5 counts with clk_sel nonzero");

    // R6: free-run wrap sets overflow
    load16(16'hFFFE, 1'b0);
    cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd1, 1'b0);
    chk({15'h0, at_top}, 16'h1, "R9 at_top at 0xFFFF mode 0");
    cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd1, 1'b0);
    chk({15'h0, at_bottom}, 16'h1, "R6 wrapped to zero");
    chk({15'h0, ovf_flag}, 16'h1, "R6 overflow on wrap");

    // R10: write zero keeps, write one clears
    cyc(2'd2, 1'b1, 1'b0, 8'hFE, 1'b0, 3'd1, 1'b0);
    chk({15'h0, ovf_flag}, 16'h1, "R10 write 0 keeps flag");
    cyc(2'd2, 1'b1, 1'b0, 8'h01, 1'b0, 3'd1, 1'b0);
    chk({15'h0, ovf_flag}, 16'h0, "R10 write 1 clears flag");
    load16(16'hFFFF, 1'b0);
    cyc(2'd2, 1'b1, 1'b0, 8'h01, 1'b1, 3'd2, 1'b0);
    chk({15'h0, ovf_flag}, 16'h1, "R10 set wins over clear");
    cyc(2'd2, 1'b1, 1'b0, 8'h01, 1'b0, 3'd1, 1'b0);

    // R7: dual slope turn at top
    load16(16'h00FE, 1'b1);
    cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd1, 1'b1);
    chk({15'h0, at_top}, 16'h1, "R9 at_top at 0x00FF mode 1");
    cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd1, 1'b1);
    look(2'd0, 8'hFE, "R7 turned down at top");
    cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd1, 1'b1);
    look(2'd0, 8'hFD, "R7 keeps going down");

    // R8: landing on zero in dual slope
    load16(16'h0002, 1'b1);
    cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd1, 1'b1);
    chk({15'h0, ovf_flag}, 16'h0, "R8 no flag before bottom");
    cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd1, 1'b1);
    chk({15'h0, ovf_flag}, 16'h1, "R8 flag on reaching bottom");
    cyc(2'd0, 1'b0, 1'b0, 8'h00, 1'b1, 3'd1, 1'b1);
    look(2'd0, 8'h01, "R7 turned up at bottom");

    // R7: above top counts down
    load16(16'h0300, 1'b1);
    cyc(2'd0, 1'b0, 1'b1, 8'h00, 1'b1, 3'd3, 1'b1);
    look(2'd0, 8'hFF, "R7 above top steps down low");
    look(2'd1, 8'h03, "R7 holding captured before step");
    cyc(2'd0, 1'b0, 1'b1, 8'h00, 1'b0, 3'd3, 1'b1);
    look(2'd1, 8'h02, "R7 above top steps down high");

    // random phase with model checks every cycle
    for (int n = 0; n < 8000; n++) begin
      logic [1:0] a;
      logic [2:0] op;
      logic       w;
      logic       r;
      logic [2:0] cs;
      logic       md;
      a  = 2'($urandom % 4);
      op = 3'($urandom % 8);
      w  = (op == 3'd0) && ($urandom % 4 == 0);
      r  = (op == 3'd1) || (op == 3'd2);
      cs = ($urandom % 8 == 0) ? 3'd0 : 3'(1 + $urandom % 7);
      md = (n < 4000);
      cyc(a, w, r, 8'($urandom), ($urandom % 4) != 0, cs, md);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule